// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core that sits beside the register file of a 16-bit signal-processing CPU. On each cycle in which the issue strobe is high it executes one operation on one of two 40-bit accumulators, and commits the result at the next clock edge. The operations are clear, load, multiply-add, multiply-subtract, plain multiply and arithmetic scaling. Products come from a signed 17-by-17 multiplier fed with the two 16-bit operands after one bit of sign extension. The eight guard bits above the 32-bit product range let long sums build up without loss. Overflow beyond 40 bits is either clamped or allowed to wrap, chosen per operation.

A 40-bit shifter moves an accumulator value up to 16 places in either direction within one cycle. After every operation a rounded 16-bit word, taken from the updated accumulator, is offered for write-back to a working register. Sticky flags for each accumulator record overflow and clamping. Operand fetch, decode and address generation happen elsewhere.

Top module: `dsp_mac_engine`

## Requirements
- R1: Op code 4 (multiply) writes the signed product of the two 16-bit operands into the selected accumulator, sign-extended to 40 bits. The extremes 0x7FFF x 0x8000 and 0x8000 x 0x8000 are exact.
- R2: Op code 2 adds the product to the selected accumulator and op code 3 subtracts it. acc_sel 0 picks accumulator 0 and 1 picks accumulator 1. The accumulator that is not selected never changes.
- R3: Op code 1 (load) places operand A, sign-extended, at accumulator bits 31:16 with zeros below. Op code 0 (clear) zeros the selected accumulator and both of its flags.
- R4: Op code 5 scales the selected accumulator by shift_amt, a 6-bit two's-complement value. A positive amount shifts right arithmetically and a negative amount shifts left. Amounts beyond +16 or -16 act as 16 in the same direction.
- R5: A result that does not fit in 40 signed bits becomes 0x7FFFFFFFFF or 0x8000000000, by its sign, when sat_en is high. When sat_en is low it keeps its low 40 bits.
- R6: ovf_flag[i] sets on any 40-bit overflow of accumulator i. sat_flag[i] sets when that overflow was clamped. Both flags stay set until a clear of that accumulator or a reset.
- R7: wb_word is bits 31:16 of the updated accumulator plus 0x8000. When sat_en is high and the rounded value lies outside the signed 16-bit range, wb_word becomes 0x7FFF or 0x8000 instead.
- R8: Every result of an operation issued with in_valid high appears on the outputs after the very next rising clock edge.
- R9: A cycle with in_valid low, or with the reserved op codes 6 or 7, changes no accumulator, no flag and no wb_word.
- R10: A synchronous active-high reset zeros both accumulators, all flags and wb_word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operation on the other inputs |
| op | input | 3 | Operation code: 0 clear, 1 load, 2 mul-add, 3 mul-sub, 4 multiply, 5 shift |
| acc_sel | input | 1 | Target accumulator |
| sat_en | input | 1 | Saturate accumulator and write-back word on this operation |
| shift_amt | input | 6 | Signed scaling amount, positive means right |
| opnd_a | input | 16 | First signed operand |
| opnd_b | input | 16 | Second signed operand |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| wb_word | output | 16 | Rounded write-back word from the last operation |
| ovf_flag | output | 2 | Sticky overflow flag per accumulator |
| sat_flag | output | 2 | Sticky clamping flag per accumulator |

## Verification
Each result of this block has one cycle of latency. The accumulators, flags and write-back word are all registered from the same issue edge, and so are due together right after it. The bench drives each operation at a falling edge and holds it through one rising edge. It then drops the strobe and reads the results at the next falling edge, before any other edge can change them. For the hold, reserved-code and reset cases the bench reads after the same single edge. No result ever needs a longer wait.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  localparam int NUM_ACC = 2;

  typedef enum logic [2:0] {
    OP_CLR   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_MAC   = 3'd2,
    OP_MSC   = 3'd3,
    OP_MPY   = 3'd4,
    OP_SHIFT = 3'd5
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
// Signed multiplier on operands widened by one sign bit.
module mac_mult #(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W + 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [PROD_W-1:0] prod
);
  logic signed [DATA_W:0]   ea, eb;
  logic signed [PROD_W-1:0] p;

  always_comb begin
    ea   = signed'({a[DATA_W-1], a});
    eb   = signed'({b[DATA_W-1], b});
    p    = PROD_W'(ea) * PROD_W'(eb);
    prod = p;
  end
endmodule

// File: rtl/mac_shift.sv
// Bidirectional arithmetic scaler; output widened so left overflow is visible.
module mac_shift #(
  parameter int ACC_W  = 40,
  parameter int SH_W   = 6,
  parameter int MAX_SH = 16,
  localparam int WIDE_W = ACC_W + MAX_SH
) (
  input  logic [ACC_W-1:0]  din,
  input  logic [SH_W-1:0]   amt,
  output logic [WIDE_W-1:0] dout
);
  logic signed [SH_W-1:0]   s;
  logic                     left;
  int                       mag;
  logic signed [WIDE_W-1:0] ext;

  always_comb begin
    s    = signed'(amt);
    left = 1'b0;
    mag  = 0;
    if (int'(s) < -MAX_SH) begin
      left = 1'b1;
      mag  = MAX_SH;
    end else if (int'(s) < 0) begin
      left = 1'b1;
      mag  = -int'(s);
    end else if (int'(s) > MAX_SH) begin
      mag  = MAX_SH;
    end else begin
      mag  = int'(s);
    end
    ext = signed'({{(WIDE_W - ACC_W){din[ACC_W-1]}}, din});
    if (left) dout = ext <<< mag;
    else      dout = ext >>> mag;
  end
endmodule

// File: rtl/mac_sat.sv
// Narrows a wide signed value to the accumulator width, clamping on demand.
module mac_sat #(
  parameter int WIDE_W = 56,
  parameter int ACC_W  = 40
) (
  input  logic [WIDE_W-1:0] din,
  input  logic              sat_en,
  output logic [ACC_W-1:0]  dout,
  output logic              ovf
);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic [WIDE_W-ACC_W:0] top;

  always_comb begin
    top = din[WIDE_W-1:ACC_W-1];
    ovf = !((&top) || !(|top));
    if (ovf && sat_en) dout = din[WIDE_W-1] ? NEG_MAX : POS_MAX;
    else               dout = din[ACC_W-1:0];
  end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine #(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 40,
  parameter int SH_W      = 6,
  parameter int MAX_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              acc_sel,
  input  logic              sat_en,
  input  logic [SH_W-1:0]   shift_amt,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [ACC_W-1:0]  acc0,
  output logic [ACC_W-1:0]  acc1,
  output logic [DATA_W-1:0] wb_word,
  output logic [1:0]        ovf_flag,
  output logic [1:0]        sat_flag
);
  import dsp_mac_pkg::*;

  localparam int WIDE_W = ACC_W + MAX_SHIFT;
  localparam int PROD_W = 2 * DATA_W + 2;
  localparam int HI_W   = ACC_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] WB_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WB_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [ACC_W-1:0]   acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] ovf_v, sat_v;
  logic [ACC_W-1:0]   acc_cur, acc_nxt;
  logic [PROD_W-1:0]  prod;
  logic [WIDE_W-1:0]  shifted, cur_w, prod_w, load_w, pre_sat;
  logic               ovf_now, op_ok, upd, is_clr;
  logic [ACC_W:0]     rnd;
  logic [HI_W-1:0]    rnd_hi;
  logic [DATA_W-1:0]  wb_nxt, wb_q;
  mac_op_e            op_e;

  mac_mult #(.DATA_W(DATA_W)) u_mult (
    .a(opnd_a), .b(opnd_b), .prod(prod)
  );

  mac_shift #(.ACC_W(ACC_W), .SH_W(SH_W), .MAX_SH(MAX_SHIFT)) u_shift (
    .din(acc_cur), .amt(shift_amt), .dout(shifted)
  );

  mac_sat #(.WIDE_W(WIDE_W), .ACC_W(ACC_W)) u_sat (
    .din(pre_sat), .sat_en(sat_en), .dout(acc_nxt), .ovf(ovf_now)
  );

  // Operation select: every path is formed at the wide width so one
  // narrowing stage serves add, subtract and left scaling alike.
  always_comb begin
    op_e    = mac_op_e'(op);
    op_ok   = (op <= 3'd5);
    upd     = in_valid && op_ok;
    is_clr  = (op_e == OP_CLR);
    acc_cur = acc_q[acc_sel];
    cur_w   = {{(WIDE_W - ACC_W){acc_cur[ACC_W-1]}}, acc_cur};
    prod_w  = {{(WIDE_W - PROD_W){prod[PROD_W-1]}}, prod};
    load_w  = {{(WIDE_W - 2*DATA_W){opnd_a[DATA_W-1]}}, opnd_a, {DATA_W{1'b0}}};
    case (op_e)
      OP_CLR:   pre_sat = '0;
      OP_LOAD:  pre_sat = load_w;
      OP_MAC:   pre_sat = cur_w + prod_w;
      OP_MSC:   pre_sat = cur_w - prod_w;
      OP_MPY:   pre_sat = prod_w;
      OP_SHIFT: pre_sat = shifted;
      default:  pre_sat = cur_w;
    endcase
  end

  // Write-back word: round to nearest on the committed value.
  always_comb begin
    rnd    = {acc_nxt[ACC_W-1], acc_nxt} + ((ACC_W+1)'(1) << (DATA_W-1));
    rnd_hi = rnd[ACC_W:DATA_W];
    if (sat_en && !((&rnd_hi[HI_W-1:DATA_W-1]) || !(|rnd_hi[HI_W-1:DATA_W-1])))
      wb_nxt = rnd_hi[HI_W-1] ? WB_MIN : WB_MAX;
    else
      wb_nxt = rnd_hi[DATA_W-1:0];
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic [ACC_W-1:0] q;
    logic             ovf_r, sat_r;
    logic             hit;

    assign hit = upd && (acc_sel == 1'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        q     <= '0;
        ovf_r <= 1'b0;
        sat_r <= 1'b0;
      end else if (hit) begin
        q <= acc_nxt;
        if (is_clr) begin
          ovf_r <= 1'b0;
          sat_r <= 1'b0;
        end else begin
          ovf_r <= ovf_r | ovf_now;
          sat_r <= sat_r | (ovf_now & sat_en);
        end
      end
    end

    assign acc_q[i] = q;
    assign ovf_v[i] = ovf_r;
    assign sat_v[i] = sat_r;
  end

  always_ff @(posedge clk) begin
    if (rst)      wb_q <= '0;
    else if (upd) wb_q <= wb_nxt;
  end

  assign acc0     = acc_q[0];
  assign acc1     = acc_q[1];
  assign wb_word  = wb_q;
  assign ovf_flag = ovf_v;
  assign sat_flag = sat_v;
endmodule

// File: rtl/dsp_mac_engine_chk.sv
module dsp_mac_engine_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int SH_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              acc_sel,
  input logic              sat_en,
  input logic [SH_W-1:0]   shift_amt,
  input logic [ACC_W-1:0]  acc0,
  input logic [ACC_W-1:0]  acc1,
  input logic [DATA_W-1:0] wb_word,
  input logic [1:0]        ovf_flag,
  input logic [1:0]        sat_flag
);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op > 3'd5) |=> ($stable(acc0) && $stable(acc1) && $stable(wb_word)
                                  && $stable(ovf_flag) && $stable(sat_flag)));

  p_other_acc1_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_sel == 1'b0) |=> $stable(acc1));

  p_other_acc0_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_sel == 1'b1) |=> $stable(acc0));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && acc_sel == 1'b0) |=>
      (acc0 == '0 && ovf_flag[0] == 1'b0 && sat_flag[0] == 1'b0 && wb_word == '0));

  p_clamp_value_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag[0]) |-> (acc0 == POS_MAX || acc0 == NEG_MAX));

  p_sticky_ovf0_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag[0] && !(in_valid && op == 3'd0 && acc_sel == 1'b0)) |=> ovf_flag[0]);

  p_sticky_ovf1_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag[1] && !(in_valid && op == 3'd0 && acc_sel == 1'b1)) |=> ovf_flag[1]);

  p_sat_implies_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (sat_flag & ~ovf_flag) == 2'b00);

  p_no_sat_without_en_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en && acc_sel == 1'b0 && op != 3'd0) |=> (sat_flag[0] == $past(sat_flag[0])));
endmodule

bind dsp_mac_engine dsp_mac_engine_chk #(
  .DATA_W(DATA_W), .ACC_W(ACC_W), .SH_W(SH_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
  .sat_en(sat_en), .shift_amt(shift_amt), .acc0(acc0), .acc1(acc1),
  .wb_word(wb_word), .ovf_flag(ovf_flag), .sat_flag(sat_flag)
);

// File: tb/dsp_mac_engine_tb.sv
`timescale 1ns/1ps
module dsp_mac_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        acc_sel = 1'b0;
  logic        sat_en = 1'b0;
  logic [5:0]  shift_amt = 6'd0;
  logic [15:0] opnd_a = 16'd0;
  logic [15:0] opnd_b = 16'd0;
  logic [39:0] acc0, acc1;
  logic [15:0] wb_word;
  logic [1:0]  ovf_flag, sat_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dsp_mac_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
    .sat_en(sat_en), .shift_amt(shift_amt), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .acc0(acc0), .acc1(acc1), .wb_word(wb_word), .ovf_flag(ovf_flag),
    .sat_flag(sat_flag)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        sel;
    logic        sat;
    logic [5:0]  sh;
    logic [15:0] a;
    logic [15:0] b;
    logic [39:0] e0;
    logic [39:0] e1;
    logic [15:0] ewb;
    logic [1:0]  eovf;
    logic [1:0]  esat;
  } vec_t;

  localparam int NV = 21;
  // op codes: 0 clear, 1 load, 2 mac, 3 msc, 4 mpy, 5 shift
  localparam vec_t TBL [NV] = '{
    '{3'd1, 1'b0, 1'b0, 6'h00, 16'h1234, 16'h0000, 40'h0012340000, 40'h0000000000, 16'h1234, 2'b00, 2'b00}, // R3 load
    '{3'd2, 1'b0, 1'b0, 6'h00, 16'h0003, 16'h0004, 40'h001234000C, 40'h0000000000, 16'h1234, 2'b00, 2'b00}, // R2 mac
    '{3'd4, 1'b1, 1'b0, 6'h00, 16'hFFFE, 16'h4000, 40'h001234000C, 40'hFFFFFF8000, 16'h0000, 2'b00, 2'b00}, // R1 R7
    '{3'd3, 1'b1, 1'b0, 6'h00, 16'h0100, 16'h0100, 40'h001234000C, 40'hFFFFFE8000, 16'hFFFF, 2'b00, 2'b00}, // R2 msc
    '{3'd4, 1'b0, 1'b0, 6'h00, 16'h7FFF, 16'h8000, 40'hFFC0008000, 40'hFFFFFE8000, 16'hC001, 2'b00, 2'b00}, // R1 extreme
    '{3'd5, 1'b0, 1'b0, 6'h04, 16'h0000, 16'h0000, 40'hFFFC000800, 40'hFFFFFE8000, 16'hFC00, 2'b00, 2'b00}, // R4 right
    '{3'd5, 1'b0, 1'b0, 6'h38, 16'h0000, 16'h0000, 40'hFC00080000, 40'hFFFFFE8000, 16'h0008, 2'b00, 2'b00}, // R4 left, R7 wrap
    '{3'd1, 1'b1, 1'b1, 6'h00, 16'h7FFF, 16'h0000, 40'hFC00080000, 40'h007FFF0000, 16'h7FFF, 2'b00, 2'b00}, // R3
    '{3'd5, 1'b1, 1'b1, 6'h38, 16'h0000, 16'h0000, 40'hFC00080000, 40'h7FFF000000, 16'h7FFF, 2'b00, 2'b00}, // R7 sat
    '{3'd5, 1'b1, 1'b0, 6'h38, 16'h0000, 16'h0000, 40'hFC00080000, 40'hFF00000000, 16'h0000, 2'b10, 2'b00}, // R5 wrap R6
    '{3'd1, 1'b1, 1'b1, 6'h00, 16'h7FFF, 16'h0000, 40'hFC00080000, 40'h007FFF0000, 16'h7FFF, 2'b10, 2'b00}, // R6 sticky
    '{3'd5, 1'b1, 1'b1, 6'h30, 16'h0000, 16'h0000, 40'hFC00080000, 40'h7FFFFFFFFF, 16'h7FFF, 2'b10, 2'b10}, // R5 clamp +
    '{3'd5, 1'b0, 1'b1, 6'h30, 16'h0000, 16'h0000, 40'h8000000000, 40'h7FFFFFFFFF, 16'h8000, 2'b11, 2'b11}, // R5 clamp -
    '{3'd0, 1'b1, 1'b0, 6'h00, 16'h5555, 16'h5555, 40'h8000000000, 40'h0000000000, 16'h0000, 2'b01, 2'b01}, // R3 clear
    '{3'd6, 1'b0, 1'b1, 6'h00, 16'h7FFF, 16'h7FFF, 40'h8000000000, 40'h0000000000, 16'h0000, 2'b01, 2'b01}, // R9 reserved
    '{3'd5, 1'b0, 1'b0, 6'h1F, 16'h0000, 16'h0000, 40'hFFFF800000, 40'h0000000000, 16'hFF80, 2'b01, 2'b01}, // R4 clamp +31
    '{3'd2, 1'b0, 1'b1, 6'h00, 16'h8000, 16'h8000, 40'h003F800000, 40'h0000000000, 16'h3F80, 2'b01, 2'b01}, // R1 R2
    '{3'd5, 1'b0, 1'b0, 6'h20, 16'h0000, 16'h0000, 40'h8000000000, 40'h0000000000, 16'h0000, 2'b01, 2'b01}, // R4 clamp -32
    '{3'd1, 1'b1, 1'b0, 6'h00, 16'h7FFF, 16'h0000, 40'h8000000000, 40'h007FFF0000, 16'h7FFF, 2'b01, 2'b01}, // R3
    '{3'd5, 1'b1, 1'b0, 6'h38, 16'h0000, 16'h0000, 40'h8000000000, 40'h7FFF000000, 16'hFF00, 2'b01, 2'b01}, // R7 wrap
    '{3'd2, 1'b1, 1'b1, 6'h00, 16'h7FFF, 16'h7FFF, 40'h8000000000, 40'h7FFFFFFFFF, 16'h7FFF, 2'b11, 2'b11}  // R5 mac clamp
  };

  task automatic chk(input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [39:0] e0, input logic [39:0] e1,
                         input logic [15:0] ewb, input logic [1:0] eovf, input logic [1:0] esat);
    chk(req, "acc0", acc0, e0);
    chk(req, "acc1", acc1, e1);
    chk(req, "wb_word", {24'd0, wb_word}, {24'd0, ewb});
    chk(req, "ovf_flag", {38'd0, ovf_flag}, {38'd0, eovf});
    chk(req, "sat_flag", {38'd0, sat_flag}, {38'd0, esat});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk_all("R10", 40'd0, 40'd0, 16'd0, 2'b00, 2'b00);

    // Vector table: R1..R7, R9; each result due after one edge (R8)
    for (int i = 0; i < NV; i++) begin
      op        = TBL[i].op;
      acc_sel   = TBL[i].sel;
      sat_en    = TBL[i].sat;
      shift_amt = TBL[i].sh;
      opnd_a    = TBL[i].a;
      opnd_b    = TBL[i].b;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      chk_all("R8 table", TBL[i].e0, TBL[i].e1, TBL[i].ewb, TBL[i].eovf, TBL[i].esat);
    end

    // R9: strobe low, a live-looking MAC on the inputs must not land
    op = 3'd2; acc_sel = 1'b1; sat_en = 1'b0; opnd_a = 16'h1111; opnd_b = 16'h2222;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_all("R9 idle", 40'h8000000000, 40'h7FFFFFFFFF, 16'h7FFF, 2'b11, 2'b11);
    end

    // R9: reserved code 7 with strobe high
    op = 3'd7; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_all("R9 code7", 40'h8000000000, 40'h7FFFFFFFFF, 16'h7FFF, 2'b11, 2'b11);

    // R10: reset in mid-run clears everything after one edge
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_all("R10 mid", 40'd0, 40'd0, 16'd0, 2'b00, 2'b00);

    // R2 R8: back-to-back MACs on alternate accumulators
    op = 3'd2; sat_en = 1'b0; in_valid = 1'b1;
    acc_sel = 1'b0; opnd_a = 16'hFFFF; opnd_b = 16'h0005;
    @(negedge clk);
    chk("R8", "acc0 b2b", acc0, 40'hFFFFFFFFFB);
    acc_sel = 1'b1; opnd_a = 16'h0010; opnd_b = 16'h0010;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "acc1 b2b", acc1, 40'h0000000100);
    chk("R2", "acc0 untouched", acc0, 40'hFFFFFFFFFB);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule